// File: doc/BRIEF.md
# IrDA SIR pulse codec

This block sits between a UART and an infrared transceiver. On the transmit side it watches the UART's serial output. For every bit cell in which that line is low, it sends one short pulse on the infrared output. A high bit produces no pulse. The pulse either lasts three ticks of the 16x baud tick, which is 3/16 of a bit, or it lasts a fixed number of system clock cycles. A 3-bit select field chooses the width. The fixed width lets a system meet the minimum pulse length of the infrared link at low baud rates. For example, 32 cycles of a 20 MHz clock gives 1.6 µs, which is above the 1.41 µs floor. For long bit periods the 3/16 setting stays within the ceiling of 3/16 of a bit plus a small margin.

On the receive side, the infrared input passes through a two-flop synchronizer. The block then looks for the start of an active pulse. Each detected pulse pulls the reconstructed UART receive line low for one full bit period, measured as sixteen baud ticks. With no pulse the line stays high. Transmit polarity and receive polarity can each be inverted. While the block is disabled, both directions are parked: the infrared output sits at its inactive level and the receive line reads idle high.

Top module: `irsir_codec`

## Requirements
- R1: After reset and while `enable` is low, `ir_txd` equals `tx_invert` (inactive level) and `uart_rxd` is 1. Activity on `uart_txd` and `ir_rxd` during that time produces no pulse and no low level.
- R2: When a clock edge with `baud_tick16` = 1 samples `uart_txd` = 0 and no bit cell is open, a transmit pulse becomes active in the first cycle after that edge. A cell in which `uart_txd` stays 1 produces no pulse.
- R3: A bit cell lasts 16 ticks. When `uart_txd` is still 0 at the 16th tick after a pulse start, the next pulse starts at that tick, so pulses for consecutive 0 bits start exactly 16 ticks apart.
- R4: With `width_sel` = 000, the pulse stays active for exactly 3 tick intervals. It ends at the edge of the third tick after its start.
- R5: With `width_sel` = k, where k is 1 to 7, the pulse stays active for exactly 2^k clock cycles. The code is captured when the pulse starts, and later changes do not alter a running pulse.
- R6: With `tx_invert` = 0, the active level of `ir_txd` is high and the idle level is low. With `tx_invert` = 1, both levels are swapped.
- R7: With `rx_invert` = 0, a rising edge on `ir_rxd` drives `uart_rxd` low from the third clock edge after the change. `uart_rxd` returns high at the edge of the 16th tick after that point.
- R8: With `rx_invert` = 1, `ir_rxd` is treated as active low, so a falling edge starts the low window of R7. Enabling the block while the input already sits at its idle level starts no window.
- R9: A new active edge during a low window restarts the 16-tick count, so the window ends 16 ticks after the latest pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low parks both directions |
| baud_tick16 | input | 1 | One-cycle strobe at 16 times the baud rate |
| uart_txd | input | 1 | Serial output of the UART |
| ir_rxd | input | 1 | Receive line from the infrared transceiver |
| width_sel | input | 3 | Pulse width code: 0 = 3 ticks, k = 2^k clock cycles |
| tx_invert | input | 1 | Invert the infrared transmit polarity |
| rx_invert | input | 1 | Treat the infrared receive input as active low |
| ir_txd | output | 1 | Pulse output to the infrared transceiver |
| uart_rxd | output | 1 | Reconstructed serial input for the UART |

## Verification
Transmit pulses are due in the first cycle after the tick edge that opens a 0 cell. Their width is either three tick intervals or 2^k cycles, and consecutive 0 cells start pulses exactly sixteen ticks apart. A receive low window begins three clock edges after the infrared line changes and ends at the edge of the sixteenth tick counted after that. The bench computes this end from its own tick counter for every stimulus. The driver records the cycle on which it changes a line. It then queues the start cycle and the length it expects. A monitor measures each pulse and each low window at mid-cycle and compares it against the head of the queue. Any activity that was not queued counts as a failure.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

    // bit cell and pulse timing
    localparam int unsigned TICKS_PER_BIT = 16;
    localparam int unsigned PHASE_W       = $clog2(TICKS_PER_BIT);
    localparam logic [PHASE_W-1:0] PHASE_LAST  = PHASE_W'(TICKS_PER_BIT - 1);
    localparam int unsigned NARROW_TICKS  = 3;
    localparam logic [PHASE_W-1:0] NARROW_LAST = PHASE_W'(NARROW_TICKS - 1);

    // clock-timed width selection
    localparam int unsigned SEL_W = 3;
    localparam int unsigned DIV_W = (1 << SEL_W) - 1;

    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic               cell_on;
        logic [PHASE_W-1:0] phase;
        logic               pulse;
        logic               clk_timed;
        logic [DIV_W-1:0]   left;
    } tx_state_t;

    localparam tx_state_t TX_IDLE = '0;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev_act;
        logic                   hold;
        logic [PHASE_W-1:0]     cnt;
    } rx_state_t;

    localparam rx_state_t RX_IDLE = '{sync: '0, prev_act: 1'b1, hold: 1'b0, cnt: '0};

    // cycles remaining after the first one for a 2^sel wide pulse
    function automatic logic [DIV_W-1:0] clk_width_m1(input logic [SEL_W-1:0] sel);
        logic [DIV_W:0] w;
        w      = '0;
        w[sel] = 1'b1;
        return DIV_W'(w - (DIV_W + 1)'(1));
    endfunction

endpackage

// File: rtl/irsir_tx_encoder.sv
module irsir_tx_encoder
    import irsir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             txd,
    input  logic [SEL_W-1:0] width_sel,
    output logic             pulse
);

    tx_state_t q, d;
    logic      start;

    always_comb begin
        d     = q;
        start = 1'b0;

        // bit cell framing on the 16x tick
        if (tick) begin
            if (q.cell_on) begin
                if (q.phase == PHASE_LAST) begin
                    d.cell_on = 1'b0;
                    d.phase   = '0;
                    start     = !txd;
                end else begin
                    d.phase = q.phase + PHASE_W'(1);
                end
            end else begin
                start = !txd;
            end
        end

        // pulse termination
        if (q.pulse) begin
            if (q.clk_timed) begin
                if (q.left == '0) begin
                    d.pulse = 1'b0;
                end else begin
                    d.left = q.left - DIV_W'(1);
                end
            end else if (tick && q.phase == NARROW_LAST) begin
                d.pulse = 1'b0;
            end
        end

        // a 0 cell opens: capture the width code
        if (start) begin
            d.cell_on   = 1'b1;
            d.phase     = '0;
            d.pulse     = 1'b1;
            d.clk_timed = (width_sel != '0);
            d.left      = clk_width_m1(width_sel);
        end

        if (!enable) begin
            d = TX_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= TX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign pulse = q.pulse;

endmodule

// File: rtl/irsir_rx_decoder.sv
module irsir_rx_decoder
    import irsir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic ir_in,
    input  logic rx_invert,
    output logic hold
);

    rx_state_t q, d;
    logic      act;
    logic      rise;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], ir_in};
        act    = q.sync[SYNC_STAGES-1] ^ rx_invert;
        rise   = act && !q.prev_act;
        d.prev_act = act;

        // hold the line low for one bit period
        if (q.hold && tick) begin
            if (q.cnt == PHASE_LAST) begin
                d.hold = 1'b0;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + PHASE_W'(1);
            end
        end

        if (rise) begin
            d.hold = 1'b1;
            d.cnt  = '0;
        end

        // parked: treat input as already active so enabling makes no edge
        if (!enable) begin
            d.hold     = 1'b0;
            d.cnt      = '0;
            d.prev_act = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign hold = q.hold;

endmodule

// File: rtl/irsir_codec.sv
module irsir_codec (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       baud_tick16,
    input  logic       uart_txd,
    input  logic       ir_rxd,
    input  logic [2:0] width_sel,
    input  logic       tx_invert,
    input  logic       rx_invert,
    output logic       ir_txd,
    output logic       uart_rxd
);

    logic tx_pulse;
    logic rx_hold;

    irsir_tx_encoder i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (baud_tick16),
        .txd       (uart_txd),
        .width_sel (width_sel),
        .pulse     (tx_pulse)
    );

    irsir_rx_decoder i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (baud_tick16),
        .ir_in     (ir_rxd),
        .rx_invert (rx_invert),
        .hold      (rx_hold)
    );

    assign ir_txd   = tx_pulse ^ tx_invert;
    assign uart_rxd = !rx_hold;

endmodule

// File: rtl/irsir_codec_chk.sv
module irsir_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic baud_tick16,
    input logic uart_txd,
    input logic tx_invert,
    input logic ir_txd,
    input logic uart_rxd
);

    logic tx_act;
    assign tx_act = ir_txd ^ tx_invert;

    // R1: parked outputs one cycle after enable is low
    a_r1_parked_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (uart_rxd && (ir_txd == tx_invert)));

    // R2: a pulse only begins after a tick that saw the UART line low
    a_r2_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_act) |-> ($past(baud_tick16) && !$past(uart_txd) && $past(enable)));

    // R7: an enabled receive window closes only on a tick
    a_r7_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(uart_rxd) && $past(enable)) |-> $past(baud_tick16));

    // R7: a receive window never opens while disabled
    a_r7_open_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uart_rxd) |-> $past(enable));

endmodule

bind irsir_codec irsir_codec_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .baud_tick16 (baud_tick16),
    .uart_txd    (uart_txd),
    .tx_invert   (tx_invert),
    .ir_txd      (ir_txd),
    .uart_rxd    (uart_rxd)
);

// File: tb/test_irsir_codec.sv
module test_irsir_codec;

    localparam int CLK_PERIOD = 10;
    localparam int TICKDIV    = 16;
    localparam int CELL       = 16 * TICKDIV;

    logic       clk = 1'b0;
    logic       rst_n, enable, uart_txd, ir_rxd, tx_invert, rx_invert;
    logic [2:0] width_sel;
    logic       baud_tick16, ir_txd, uart_rxd;
    int         cyc = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;
    assign baud_tick16 = (cyc % TICKDIV) == 0;

    irsir_codec i_irsir_codec (
        .clk(clk), .rst_n(rst_n), .enable(enable), .baud_tick16(baud_tick16),
        .uart_txd(uart_txd), .ir_rxd(ir_rxd), .width_sel(width_sel),
        .tx_invert(tx_invert), .rx_invert(rx_invert),
        .ir_txd(ir_txd), .uart_rxd(uart_rxd)
    );

    typedef struct { int start; int len; string req; } exp_t;
    exp_t tx_q[$];
    exp_t rx_q[$];
    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int tx_width(input logic [2:0] s);
        return (s == 3'd0) ? 3 * TICKDIV : (1 << s);
    endfunction

    function automatic int rx_release(input int c);
        int first;
        first = ((c + 2) / TICKDIV + 1) * TICKDIV;
        return first + 15 * TICKDIV;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_slot();
        do begin
            @(negedge clk);
            #1;
        end while (cyc % TICKDIV != 0);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit expect_it, input string req);
        logic [9:0] f;
        f = {1'b1, b, 1'b0};
        wait_slot();
        for (int i = 0; i < 10; i++) begin
            uart_txd = f[i];
            if (!f[i] && expect_it)
                tx_q.push_back('{start: cyc + 1, len: tx_width(width_sel), req: req});
            step(CELL);
        end
        uart_txd = 1'b1;
        step(CELL / 2);
    endtask

    // R5: width code changes while a pulse runs
    task automatic send_zero_change();
        wait_slot();
        uart_txd = 1'b0;
        tx_q.push_back('{start: cyc + 1, len: 16, req: "R5"});
        step(3);
        width_sel = 3'd1;
        step(CELL - 3);
        uart_txd = 1'b1;
        step(CELL);
    endtask

    task automatic rx_pulse(input bit expect_it, input string req, input int gap);
        int c, c_last;
        step(1);
        c = cyc;
        c_last = c;
        ir_rxd = !rx_invert;
        step(5);
        ir_rxd = rx_invert;
        if (gap > 0) begin
            step(gap - 5);
            c_last = cyc;
            ir_rxd = !rx_invert;
            step(5);
            ir_rxd = rx_invert;
        end
        if (expect_it)
            rx_q.push_back('{start: c + 3, len: rx_release(c_last) - c - 2, req: req});
        step(CELL + 4 * TICKDIV);
    endtask

    // monitor / scoreboard
    initial begin : mon
        bit   tprev, rprev, ta, ra;
        int   ts, rs;
        exp_t e;
        tprev = 0; rprev = 0; ts = 0; rs = 0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n === 1'b1) begin
                ta = ir_txd ^ tx_invert;
                ra = !uart_rxd;
                if (ta && !tprev) ts = cyc;
                if (!ta && tprev) begin
                    if (tx_q.size() == 0) begin
                        check(0, enable ? "R2" : "R1", "unexpected IR pulse start", ts, -1);
                    end else begin
                        e = tx_q.pop_front();
                        check(ts == e.start, e.req, "pulse start cycle", ts, e.start);
                        check(cyc - ts == e.len, e.req, "pulse width", cyc - ts, e.len);
                    end
                end
                if (ra && !rprev) rs = cyc;
                if (!ra && rprev) begin
                    if (rx_q.size() == 0) begin
                        check(0, enable ? "R7" : "R1", "unexpected RX low start", rs, -1);
                    end else begin
                        e = rx_q.pop_front();
                        check(rs == e.start, e.req, "rx low start cycle", rs, e.start);
                        check(cyc - rs == e.len, e.req, "rx low length", cyc - rs, e.len);
                    end
                end
                tprev = ta;
                rprev = ra;
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL all-requirements watchdog: actual 150000 cycles expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 0; enable = 0; uart_txd = 1; ir_rxd = 0;
        width_sel = 3'd0; tx_invert = 0; rx_invert = 0;
        step(4);
        check(ir_txd == 1'b0, "R1", "ir_txd in reset", ir_txd, 0);
        check(uart_rxd == 1'b1, "R1", "uart_rxd in reset", uart_rxd, 1);
        rst_n = 1;
        step(3);
        enable = 1;
        step(4);

        // R2 and R4: 3/16 pulses, mixed bits
        send_frame(8'hA5, 1, "R4");
        send_frame(8'hFF, 1, "R2");
        // R3: nine consecutive zero cells
        send_frame(8'h00, 1, "R3");

        // R5: clock-timed widths for every non-zero code
        for (int s = 1; s < 8; s++) begin
            width_sel = 3'(s);
            send_frame(8'h6C, 1, "R5");
        end
        width_sel = 3'd4;
        send_zero_change();
        width_sel = 3'd0;

        // R6: inverted transmit polarity
        tx_invert = 1;
        step(2);
        check(ir_txd == 1'b1, "R6", "idle ir_txd inverted", ir_txd, 1);
        send_frame(8'h3A, 1, "R6");
        tx_invert = 0;
        step(2);
        check(ir_txd == 1'b0, "R6", "idle ir_txd normal", ir_txd, 0);

        // R7: single pulses, R9: retrigger
        rx_pulse(1, "R7", 0);
        rx_pulse(1, "R7", 0);
        rx_pulse(1, "R9", 6 * TICKDIV);

        // R8: switch to active-low input while parked
        enable = 0;
        ir_rxd = 1;
        rx_invert = 1;
        step(4);
        enable = 1;
        step(4);
        check(uart_rxd == 1'b1, "R8", "no window on enable with idle-high input", uart_rxd, 1);
        rx_pulse(1, "R8", 0);
        enable = 0;
        ir_rxd = 0;
        rx_invert = 0;
        step(4);
        enable = 1;
        step(4);

        // R1: disabled block ignores both directions
        enable = 0;
        step(2);
        check(uart_rxd == 1'b1, "R1", "uart_rxd while disabled", uart_rxd, 1);
        check(ir_txd == tx_invert, "R1", "ir_txd while disabled", ir_txd, tx_invert);
        send_frame(8'h00, 0, "R1");
        rx_pulse(0, "R1", 0);
        check(uart_rxd == 1'b1, "R1", "uart_rxd after disabled pulse", uart_rxd, 1);
        tx_invert = 1;
        step(1);
        check(ir_txd == 1'b1, "R1", "inactive level follows tx_invert while disabled", ir_txd, 1);
        tx_invert = 0;
        enable = 1;
        step(CELL);

        check(tx_q.size() == 0, "R2", "missing IR pulses", tx_q.size(), 0);
        check(rx_q.size() == 0, "R7", "missing RX windows", rx_q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule